// File: doc/BRIEF.md
# Key Input Match-Change Interrupt Detector

This block watches two groups of key-input pins and raises an interrupt when a group stops matching a programmed pattern. Channel 0 looks at five pins and channel 1 at four. Each channel takes its pins from one of five candidate 8-bit ports. Channel 0 uses bits 4..0 of the chosen port and channel 1 uses bits 7..4. A per-pin mask decides which pins take part. A per-pin compare value gives the level counted as "matching", which in effect picks a rising or falling edge for each pin.

All port inputs pass through a two-flop synchroniser. A channel records whether its enabled pins matched on the previous cycle. When they go from matching to not matching, a sticky factor flag is set. Software clears the flag by writing 1 to it. The interrupt output of a channel is the flag gated by that channel's enable bit. Software programs the block through a small write/read register bus with a combinational read path.

Top module: `keyint_detect`

## Requirements
- R1: After reset, every register reads 0, both flags are clear and both interrupt outputs are low.
- R2: Group selection works as follows. When a channel's extension bit is 1, the channel uses `port_e`. When it is 0, select value 0, 1, 2 or 3 picks `port_a`, `port_b`, `port_c` or `port_d`. Channel 0 uses bits 4..0 of the chosen port and channel 1 uses bits 7..4. A change on a port that is not selected never sets a flag.
- R3: A pin whose mask bit is 0 takes no part in the comparison, so a change on that pin never sets the flag.
- R4: A flag is set when the channel's masked pins go from equal to the masked compare value to unequal. A port change driven before rising edge k is visible in the flag after edge k+2.
- R5: A mismatch that continues without first returning to a match does not set the flag again after it has been cleared.
- R6: Writing 1 to a flag bit at address 4 clears that flag. Writing 0 leaves it unchanged. If a new match-to-mismatch event happens in the same cycle as the clear, the flag ends up set.
- R7: `irq0` equals flag 0 AND enable 0, and `irq1` equals flag 1 AND enable 1, in every cycle.
- R8: The register map is as follows. Address 0 holds the channel 0 mask in bits 4..0. Address 1 holds the channel 0 compare value in bits 4..0. Address 2 holds the channel 1 mask in bits 3..0 and the channel 1 compare value in bits 7..4. Address 3 holds select 0 in bits 1..0, select 1 in bits 3..2, extension 0 in bit 4, extension 1 in bit 5, enable 0 in bit 6 and enable 1 in bit 7. Address 4 holds flag 0 in bit 0 and flag 1 in bit 1. Unused bits and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| port_a | input | 8 | Candidate group 0 |
| port_b | input | 8 | Candidate group 1 |
| port_c | input | 8 | Candidate group 2 |
| port_d | input | 8 | Candidate group 3 |
| port_e | input | 8 | Extension group |
| irq0 | output | 1 | Channel 0 interrupt request |
| irq1 | output | 1 | Channel 1 interrupt request |

## Verification
The bench toggles a masked-out pin, which a design that ignored the mask would flag. It toggles ports that are not selected, which a design that decoded the select wrongly would flag. It clears the flag while a mismatch continues; a level-sensitive detector would set the flag again at once. It issues a clear in exactly the cycle an event arrives, where a design that let the clear win would lose the interrupt. It also turns the enable off while the flag is held, and the interrupt output must drop without the flag being lost.

// File: rtl/keyint_pkg.sv
// Shared constants, register addresses and group-index helper for the
// key input match-change detector.
package keyint_pkg;
    localparam int NUM_GRP   = 5;
    localparam int GRP_IDX_W = $clog2(NUM_GRP);
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK0 = 3'd0,
        A_CMP0  = 3'd1,
        A_CH1   = 3'd2,
        A_SEL   = 3'd3,
        A_FLAG  = 3'd4
    } reg_addr_e;

    // Extension bit overrides the 2-bit select and picks the last group.
    function automatic logic [GRP_IDX_W-1:0] grp_index(input logic [1:0] sel, input logic ext);
        return ext ? GRP_IDX_W'(NUM_GRP - 1) : GRP_IDX_W'(sel);
    endfunction
endpackage

// File: rtl/keyint_sync.sv
// Two-flop synchroniser for a bus of asynchronous pins, plus a valid
// shift that rises once the second stage holds a real sample.
// Assumes each pin is independent (no bus coherency needed).
module keyint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         valid
);
    logic [W-1:0] stage1;
    logic [1:0]   vld_sr;

    // Shift pins through two flops and track sample validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
            vld_sr <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            vld_sr <= {vld_sr[0], 1'b1};
        end
    end

    assign valid = vld_sr[1];
endmodule

// File: rtl/keyint_chan.sv
// One key-input channel: picks a W-bit slice at offset LSB from one of
// NGRP ports, compares masked pins to a pattern, and sets a sticky flag
// on a match-to-mismatch transition. Assumes synchronised inputs.
module keyint_chan
    import keyint_pkg::*;
#(
    parameter int W      = 5,
    parameter int LSB    = 0,
    parameter int PORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*PORT_W-1:0] ports,
    input  logic                     valid,
    input  logic [GRP_IDX_W-1:0]     grp_idx,
    input  logic [W-1:0]             mask,
    input  logic [W-1:0]             cmp,
    input  logic                     clr,
    output logic                     flag
);
    logic [W-1:0] grp [NUM_GRP];
    logic [W-1:0] grp_sel;
    logic         match;
    logic         prev_match;
    logic         primed;
    logic         event_hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
        assign grp[g] = ports[g*PORT_W + LSB +: W];
    end

    // Route the selected group to the comparator.
    always_comb begin
        grp_sel = '0;
        if (grp_idx < GRP_IDX_W'(NUM_GRP)) grp_sel = grp[grp_idx];
    end

    assign match     = ((grp_sel ^ cmp) & mask) == '0;
    assign event_hit = primed && prev_match && !match;

    // Remember last match state once real samples arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_match <= 1'b0;
            primed     <= 1'b0;
        end else begin
            primed <= valid;
            if (valid) prev_match <= match;
        end
    end

    // Sticky factor flag: event sets, write-1 clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (event_hit) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    // R3
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> match);
    // R4
    set_on_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && prev_match && !match) |=> flag);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(primed && prev_match && !match) && !clr) |=> $stable(flag));
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(primed && prev_match && !match)) |=> !flag);
endmodule

// File: rtl/keyint_detect.sv
// Top of the key input match-change interrupt detector: register file,
// input synchroniser and two channels (5-bit low slice, 4-bit high slice).
// Assumes W1 <= 4 so channel 1 mask and compare share one register.
module keyint_detect
    import keyint_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int W0     = 5,
    parameter int W1     = 4,
    parameter int W1_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PORT_W-1:0] port_a,
    input  logic [PORT_W-1:0] port_b,
    input  logic [PORT_W-1:0] port_c,
    input  logic [PORT_W-1:0] port_d,
    input  logic [PORT_W-1:0] port_e,
    output logic              irq0,
    output logic              irq1
);
    localparam int BUS_W = NUM_GRP * PORT_W;

    logic [W0-1:0] mask0_q, cmp0_q;
    logic [W1-1:0] mask1_q, cmp1_q;
    logic [1:0]    sel0_q, sel1_q;
    logic          ext0_q, ext1_q, en0_q, en1_q;
    logic [BUS_W-1:0] ports_s;
    logic          s_valid;
    logic          flag0, flag1, clr0, clr1;
    logic          flag_wr;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask0_q <= '0; cmp0_q <= '0;
            mask1_q <= '0; cmp1_q <= '0;
            sel0_q  <= '0; sel1_q <= '0;
            ext0_q  <= 1'b0; ext1_q <= 1'b0;
            en0_q   <= 1'b0; en1_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_MASK0: mask0_q <= wdata[W0-1:0];
                A_CMP0:  cmp0_q  <= wdata[W0-1:0];
                A_CH1: begin
                    mask1_q <= wdata[W1-1:0];
                    cmp1_q  <= wdata[4 +: W1];
                end
                A_SEL: begin
                    sel0_q <= wdata[1:0];
                    sel1_q <= wdata[3:2];
                    ext0_q <= wdata[4];
                    ext1_q <= wdata[5];
                    en0_q  <= wdata[6];
                    en1_q  <= wdata[7];
                end
                default: ;
            endcase
        end
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_MASK0: rdata[W0-1:0] = mask0_q;
            A_CMP0:  rdata[W0-1:0] = cmp0_q;
            A_CH1: begin
                rdata[W1-1:0]  = mask1_q;
                rdata[4 +: W1] = cmp1_q;
            end
            A_SEL:   rdata = {en1_q, en0_q, ext1_q, ext0_q, sel1_q, sel0_q};
            A_FLAG:  rdata[1:0] = {flag1, flag0};
            default: rdata = '0;
        endcase
    end

    assign flag_wr = wr_en && (addr == A_FLAG);
    assign clr0    = flag_wr && wdata[0];
    assign clr1    = flag_wr && wdata[1];

    keyint_sync #(.W(BUS_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({port_e, port_d, port_c, port_b, port_a}),
        .q(ports_s), .valid(s_valid)
    );

    keyint_chan #(.W(W0), .LSB(0), .PORT_W(PORT_W)) u_ch0 (
        .clk(clk), .rst_n(rst_n), .ports(ports_s), .valid(s_valid),
        .grp_idx(grp_index(sel0_q, ext0_q)), .mask(mask0_q), .cmp(cmp0_q),
        .clr(clr0), .flag(flag0)
    );

    keyint_chan #(.W(W1), .LSB(W1_LSB), .PORT_W(PORT_W)) u_ch1 (
        .clk(clk), .rst_n(rst_n), .ports(ports_s), .valid(s_valid),
        .grp_idx(grp_index(sel1_q, ext1_q)), .mask(mask1_q), .cmp(cmp1_q),
        .clr(clr1), .flag(flag1)
    );

    assign irq0 = flag0 && en0_q;
    assign irq1 = flag1 && en1_q;

    // R8
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK0) |=> (mask0_q == $past(wdata[W0-1:0])));
    // R1
    reset_irq_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq0 && !irq1));
endmodule

// File: tb/keyint_detect_test.sv
module keyint_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] prt [5];
    wire  [7:0] rdata;
    wire        irq0, irq1;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    // reference model state
    logic [39:0] m_s1, m_s2;
    int          m_cnt;
    bit          m_primed;
    bit          m_prev [2];
    bit          m_flag [2];
    bit          t_mt [2];
    bit          t_nf [2];
    bit          t_valid;
    logic [7:0]  m_mask0, m_cmp0, m_ch1, m_sel;

    always #5 clk = ~clk;

    keyint_detect uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .port_a(prt[0]), .port_b(prt[1]), .port_c(prt[2]),
        .port_d(prt[3]), .port_e(prt[4]), .irq0(irq0), .irq1(irq1)
    );

    function automatic bit m_match(int ch);
        int idx;
        logic [7:0] p;
        logic [4:0] g, mk, cp;
        if (ch == 0) idx = m_sel[4] ? 4 : int'(m_sel[1:0]);
        else         idx = m_sel[5] ? 4 : int'(m_sel[3:2]);
        p = m_s2[idx*8 +: 8];
        if (ch == 0) begin
            g = p[4:0]; mk = m_mask0[4:0]; cp = m_cmp0[4:0];
        end else begin
            g = {1'b0, p[7:4]}; mk = {1'b0, m_ch1[3:0]}; cp = {1'b0, m_ch1[7:4]};
        end
        return ((g ^ cp) & mk) == 5'd0;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_mask0;
            3'd1: return m_cmp0;
            3'd2: return m_ch1;
            3'd3: return m_sel;
            3'd4: return {6'd0, m_flag[1], m_flag[0]};
            default: return 8'd0;
        endcase
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_cnt = 0; m_primed = 0;
            m_prev[0] = 0; m_prev[1] = 0; m_flag[0] = 0; m_flag[1] = 0;
            m_mask0 = 0; m_cmp0 = 0; m_ch1 = 0; m_sel = 0;
        end else begin
            t_valid = (m_cnt >= 2);
            for (int c = 0; c < 2; c++) begin
                t_mt[c] = m_match(c);
                t_nf[c] = (m_primed && m_prev[c] && !t_mt[c]) ||
                          (m_flag[c] && !(wr_en && addr == 3'd4 && wdata[c]));
            end
            for (int c = 0; c < 2; c++) begin
                if (t_valid) m_prev[c] = t_mt[c];
                m_flag[c] = t_nf[c];
            end
            m_primed = t_valid;
            if (m_cnt < 2) m_cnt++;
            if (wr_en) begin
                case (addr)
                    3'd0: m_mask0 = wdata & 8'h1F;
                    3'd1: m_cmp0  = wdata & 8'h1F;
                    3'd2: m_ch1   = wdata;
                    3'd3: m_sel   = wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = {prt[4], prt[3], prt[2], prt[1], prt[0]};
        end
    end

    task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of interrupt outputs (R7)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({7'd0, irq0}, {7'd0, m_flag[0] && m_sel[6]}, "R7 irq0");
            chk({7'd0, irq1}, {7'd0, m_flag[1] && m_sel[7]}, "R7 irq1");
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        addr = a;
        #1 chk(rdata, m_read(a), tag);
    endtask

    // read flag register and compare one bit with a fixed expectation
    task automatic rd_flag(int ch, bit exp, string tag);
        @(negedge clk);
        addr = 3'd4;
        #1 chk({7'd0, rdata[ch]}, {7'd0, exp}, tag);
        chk(rdata, m_read(3'd4), tag);
    endtask

    task automatic drive(int p, logic [7:0] v);
        @(negedge clk);
        prt[p] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) prt[i] = 8'h00;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 5; a++) rd(3'(a), "R1 reset");
        chk({6'd0, irq1, irq0}, 8'd0, "R1 irq low");

        // R8 register map read-back
        wr(3'd0, 8'hFF); rd(3'd0, "R8 mask0");
        chk(rdata, 8'h1F, "R8 mask0 width");
        wr(3'd1, 8'hEA); rd(3'd1, "R8 cmp0");
        wr(3'd2, 8'h5C); rd(3'd2, "R8 ch1");
        wr(3'd3, 8'h3C); rd(3'd3, "R8 sel");
        rd(3'd5, "R8 unused");
        wr(3'd4, 8'h03); idle(4);

        // channel 0 on port_a: mask 11110, compare 11010
        wr(3'd3, 8'h40);
        wr(3'd0, 8'h1E); wr(3'd1, 8'h1A); wr(3'd2, 8'h00);
        drive(0, 8'h1A); idle(5);
        wr(3'd4, 8'h03); idle(2);
        rd_flag(0, 0, "R1 start clear");
        drive(0, 8'h1B); idle(5);
        rd_flag(0, 0, "R3 masked pin");
        drive(0, 8'h1F); idle(5);
        rd_flag(0, 1, "R4 match break");
        chk({7'd0, irq0}, 8'd1, "R7 irq0 set");
        wr(3'd4, 8'h01); idle(5);
        rd_flag(0, 0, "R5 no rearm");
        drive(0, 8'h1A); idle(4);
        drive(0, 8'h0A); idle(5);
        rd_flag(0, 1, "R4 second break");
        wr(3'd4, 8'h00); rd_flag(0, 1, "R6 write zero");
        wr(3'd3, 8'h00); idle(1);
        chk({7'd0, irq0}, 8'd0, "R7 enable off");
        rd_flag(0, 1, "R7 flag kept");
        wr(3'd3, 8'h40);

        // R6 clear coinciding with an event: set wins
        wr(3'd4, 8'h01);
        drive(0, 8'h1A); idle(5);
        rd_flag(0, 0, "R6 cleared");
        drive(0, 8'h18);
        idle(2);
        wr(3'd4, 8'h01);
        rd_flag(0, 1, "R6 set wins");
        wr(3'd4, 8'h01); idle(2);
        rd_flag(0, 0, "R6 clear");

        // channel 1 group selection sweep, mask 1111 compare 1010
        wr(3'd2, 8'hAF);
        for (int s = 0; s < 5; s++) begin
            for (int i = 0; i < 5; i++) drive(i, 8'hA0 | (prt[i] & 8'h0F));
            if (s == 4) wr(3'd3, 8'hE0);
            else        wr(3'd3, 8'h80 | 8'(s << 2));
            idle(5);
            wr(3'd4, 8'h02); idle(2);
            rd_flag(1, 0, "R2 matched");
            drive((s + 1) % 5, 8'h50 | (prt[(s + 1) % 5] & 8'h0F)); idle(5);
            rd_flag(1, 0, "R2 other port");
            drive(s, 8'h20 | (prt[s] & 8'h0F)); idle(5);
            rd_flag(1, 1, "R2 selected port");
            chk({7'd0, irq1}, 8'd1, "R7 irq1");
        end

        idle(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule